// File: doc/BRIEF.md
# Free-Space Gated Read-Request Enable

This block decides, every clock, whether a new read DMA may be requested into a transmit data buffer shared by four read channels. Each channel keeps the length of the send buffer it is about to fetch. The block adds the four pending lengths and raises a request-enable only when the buffer's reported free space is strictly greater than that total. The enable therefore admits a request only when every pending transfer still fits.

A select input chooses what feeds the adder. When low, the adder reads the four per-channel length registers. When high, it reads an alternate set of four length inputs, and the registers keep their contents. A channel's length is reloaded when its next transfer is set up and cleared when the channel reports completion, so its space returns to the pool.

The length registers are cleared at reset, and reset leaves them through a two-stage synchronizer. This prevents a reset edge that lands near a clock edge from leaving random lengths behind. Random lengths could add up past the free space and hold the enable low indefinitely. The enable and the registered sum both follow their inputs with a single clock of delay.

Top module: `dma_space_gate`

## Requirements
- R1: When a channel's bit in `lenLoadVld` is high at a rising edge, that channel's length register takes its slice of `lenLoadVal`. Channel n uses bits [16n+15:16n]. The new value appears in `lenSum` after the following rising edge.
- R2: `reqEnable` is high only when `freeSpace` is strictly greater than the adder's total. When `freeSpace` equals or is less than the total, `reqEnable` is low.
- R3: With `altSel` low, the adder sums the four length registers. With `altSel` high, it sums the four slices of `altLen` in the same bit layout, and the length registers keep their values, which reappear once `altSel` returns low.
- R4: When a channel's `chDone` bit is high at a rising edge and its load bit is low, that channel's length becomes zero. When both are high in the same cycle, the load wins.
- R5: While `rstAsyncN` is low, the length registers, `lenSum` and `reqEnable` are zero at once, without waiting for a clock. After `rstAsyncN` rises, loads at the first rising edge are ignored, because release passes through two flops.
- R6: The total spans the full sum of four maximum lengths (18 bits for 16-bit lengths) without wrapping. The comparison uses that full width.
- R7: Lengths large enough to hold `reqEnable` low are fully replaced when new lengths are loaded into all four channels. The gate then opens again as soon as the new total is below `freeSpace`.
- R8: `reqEnable` and `lenSum` are registered. A change on `freeSpace`, `altSel` or `altLen` appears on them after exactly one rising edge, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstAsyncN | input | 1 | Active-low reset, asserted asynchronously, released through a synchronizer |
| lenLoadVld | input | 4 | Per-channel length load strobes |
| lenLoadVal | input | 64 | Four 16-bit lengths, channel n at bits [16n+15:16n] |
| chDone | input | 4 | Per-channel completion strobes; clear that channel's length |
| altSel | input | 1 | Adder input select: 0 length registers, 1 alternate inputs |
| altLen | input | 64 | Four 16-bit alternate lengths, same layout as lenLoadVal |
| freeSpace | input | 18 | Free space currently reported for the transmit buffer |
| reqEnable | output | 1 | High when a new read DMA request may be issued |
| lenSum | output | 18 | Registered total presented to the comparator |

## Verification
A wrong length register stays hidden while `altSel` is high. It shows up on `lenSum` one edge after the select returns low, or two edges after a load. A bad comparator shows up on `reqEnable` at the one-unit boundary around the total. Stimulus therefore sits exactly at total and total+1 free space, including the full-scale case. A fault in the reset release would show as a load that is captured during the synchronizer cycles, visible two edges later on `lenSum`.

// File: rtl/dmagate_pkg.sv
package dmagate_pkg;

  // Number of read channels sharing the transmit buffer.
  localparam int NUM_CH = 4;

  // Per-channel strobes from control to datapath.
  typedef struct packed {
    logic [NUM_CH-1:0] load;   // capture new length
    logic [NUM_CH-1:0] clear;  // zero the length (completion)
  } chStrobe_t;

endpackage

// File: rtl/dmagate_ctrl.sv
module dmagate_ctrl
  import dmagate_pkg::*;
(
  input  logic              clk,
  input  logic              rstAsyncN,
  input  logic [NUM_CH-1:0] lenLoadVld,
  input  logic [NUM_CH-1:0] chDone,
  output logic              rstSyncN,
  output chStrobe_t         strobes
);

  // Reset synchronizer: asserts at once, releases after two edges.
  logic rstMeta;

  always_ff @(posedge clk or negedge rstAsyncN) begin
    if (!rstAsyncN) begin
      rstMeta  <= 1'b0;
      rstSyncN <= 1'b0;
    end else begin
      rstMeta  <= 1'b1;
      rstSyncN <= rstMeta;
    end
  end

  // A load outranks a completion on the same channel.
  always_comb begin
    strobes.load  = lenLoadVld;
    strobes.clear = chDone & ~lenLoadVld;
  end

  // R5: the synchronized reset is low whenever the raw reset is low.
  a_r5_sync_follows_assert: assert property (@(posedge clk)
    !rstAsyncN |-> !rstSyncN);

  // R5: release only after the raw reset was seen high on the prior edge.
  a_r5_sync_release: assert property (@(posedge clk) disable iff (!rstAsyncN)
    $rose(rstSyncN) |-> $past(rstAsyncN));

endmodule

// File: rtl/dmagate_dp.sv
module dmagate_dp
  import dmagate_pkg::*;
#(
  parameter int LEN_W  = 16,
  parameter int FREE_W = 18
) (
  input  logic                       clk,
  input  logic                       rstSyncN,
  input  chStrobe_t                  strobes,
  input  logic [NUM_CH*LEN_W-1:0]    lenLoadVal,
  input  logic [NUM_CH*LEN_W-1:0]    altLen,
  input  logic                       altSel,
  input  logic [FREE_W-1:0]          freeSpace,
  output logic                       reqEnable,
  output logic [LEN_W+$clog2(NUM_CH)-1:0] lenSum
);

  localparam int SUM_W = LEN_W + $clog2(NUM_CH);
  localparam int CMP_W = (SUM_W > FREE_W) ? SUM_W : FREE_W;

  logic [LEN_W-1:0] lenQ  [NUM_CH];
  logic [LEN_W-1:0] addIn [NUM_CH];
  logic [SUM_W-1:0] sumNext;
  logic             gateNext;

  // Per-channel pending length registers.
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_len
    always_ff @(posedge clk or negedge rstSyncN) begin
      if (!rstSyncN)
        lenQ[ch] <= '0;
      else if (strobes.load[ch])
        lenQ[ch] <= lenLoadVal[ch*LEN_W +: LEN_W];
      else if (strobes.clear[ch])
        lenQ[ch] <= '0;
    end

    // Adder input select.
    assign addIn[ch] = altSel ? altLen[ch*LEN_W +: LEN_W] : lenQ[ch];

    // R1: a load lands in its channel register.
    a_r1_load_captured: assert property (@(posedge clk) disable iff (!rstSyncN)
      strobes.load[ch] |=> (lenQ[ch] == $past(lenLoadVal[ch*LEN_W +: LEN_W])));

    // R4: completion without load empties the channel.
    a_r4_clear_on_done: assert property (@(posedge clk) disable iff (!rstSyncN)
      strobes.clear[ch] |=> (lenQ[ch] == '0));

    // R3: registers hold while nothing targets them.
    a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rstSyncN)
      (!strobes.load[ch] && !strobes.clear[ch]) |=> $stable(lenQ[ch]));
  end

  // Full-width adder over all channels.
  always_comb begin
    sumNext = '0;
    for (int ch = 0; ch < NUM_CH; ch++)
      sumNext = sumNext + SUM_W'(addIn[ch]);
  end

  assign gateNext = CMP_W'(freeSpace) > CMP_W'(sumNext);

  always_ff @(posedge clk or negedge rstSyncN) begin
    if (!rstSyncN) begin
      lenSum    <= '0;
      reqEnable <= 1'b0;
    end else begin
      lenSum    <= sumNext;
      reqEnable <= gateNext;
    end
  end

  // R2: never enabled unless the prior free space exceeded the total.
  a_r2_gate_strict: assert property (@(posedge clk) disable iff (!rstSyncN)
    reqEnable |-> (CMP_W'($past(freeSpace)) > CMP_W'(lenSum)));

  // R6: with register inputs held, the total never falls below any single length.
  a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rstSyncN)
    ($past(!altSel) && $past(!altSel, 2) && $stable(lenQ[0])) |->
      (lenSum >= SUM_W'(lenQ[0])));

endmodule

// File: rtl/dma_space_gate.sv
module dma_space_gate
  import dmagate_pkg::*;
#(
  parameter int LEN_W  = 16,
  parameter int FREE_W = 18
) (
  input  logic                             clk,
  input  logic                             rstAsyncN,
  input  logic [NUM_CH-1:0]                lenLoadVld,
  input  logic [NUM_CH*LEN_W-1:0]          lenLoadVal,
  input  logic [NUM_CH-1:0]                chDone,
  input  logic                             altSel,
  input  logic [NUM_CH*LEN_W-1:0]          altLen,
  input  logic [FREE_W-1:0]                freeSpace,
  output logic                             reqEnable,
  output logic [LEN_W+$clog2(NUM_CH)-1:0]  lenSum
);

  logic      rstSyncN;
  chStrobe_t strobes;

  dmagate_ctrl u_ctrl (
    .clk        (clk),
    .rstAsyncN  (rstAsyncN),
    .lenLoadVld (lenLoadVld),
    .chDone     (chDone),
    .rstSyncN   (rstSyncN),
    .strobes    (strobes)
  );

  dmagate_dp #(
    .LEN_W  (LEN_W),
    .FREE_W (FREE_W)
  ) u_dp (
    .clk        (clk),
    .rstSyncN   (rstSyncN),
    .strobes    (strobes),
    .lenLoadVal (lenLoadVal),
    .altLen     (altLen),
    .altSel     (altSel),
    .freeSpace  (freeSpace),
    .reqEnable  (reqEnable),
    .lenSum     (lenSum)
  );

endmodule

// File: tb/dma_space_gate_tb.sv
`timescale 1ns/1ps
module dma_space_gate_tb;

  logic        clk = 1'b0;
  logic        rstAsyncN;
  logic [3:0]  lenLoadVld;
  logic [63:0] lenLoadVal;
  logic [3:0]  chDone;
  logic        altSel;
  logic [63:0] altLen;
  logic [17:0] freeSpace;
  logic        reqEnable;
  logic [17:0] lenSum;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;   // 50 MHz

  dma_space_gate u_dut (
    .clk(clk), .rstAsyncN(rstAsyncN), .lenLoadVld(lenLoadVld),
    .lenLoadVal(lenLoadVal), .chDone(chDone), .altSel(altSel),
    .altLen(altLen), .freeSpace(freeSpace), .reqEnable(reqEnable),
    .lenSum(lenSum)
  );

  // {altSel, freeSpace[17:0], len3, len2, len1, len0}
  localparam int NV = 8;
  localparam logic [82:0] VEC [NV] = '{
    {1'b0, 18'd100,    16'd39,    16'd30,    16'd20,    16'd10},
    {1'b0, 18'd100,    16'd40,    16'd30,    16'd20,    16'd10},
    {1'b1, 18'd500,    16'd100,   16'd100,   16'd100,   16'd100},
    {1'b1, 18'd400,    16'd100,   16'd100,   16'd100,   16'd100},
    {1'b0, 18'd0,      16'd0,     16'd0,     16'd0,     16'd0},
    {1'b0, 18'd1,      16'd0,     16'd0,     16'd0,     16'd0},
    {1'b0, 18'd262143, 16'hFFFF,  16'hFFFF,  16'hFFFF,  16'hFFFF},
    {1'b0, 18'd262140, 16'hFFFF,  16'hFFFF,  16'hFFFF,  16'hFFFF}
  };

  task automatic chk(input string req, input string what, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic loadAll(input logic [15:0] l3, l2, l1, l0);
    @(negedge clk);
    lenLoadVal = {l3, l2, l1, l0};
    lenLoadVld = 4'hF;
    @(negedge clk);
    lenLoadVld = 4'h0;
    @(negedge clk);
  endtask

  initial begin
    #4_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog R2: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rstAsyncN = 1'b0; lenLoadVld = '0; lenLoadVal = '0; chDone = '0;
    altSel = 1'b0; altLen = '0; freeSpace = 18'd5;

    // R5: reset state while held
    repeat (3) @(negedge clk);
    chk("R5", "reset lenSum", lenSum, 0);
    chk("R5", "reset reqEnable", reqEnable, 0);
    rstAsyncN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2", "enable with zero lengths", reqEnable, 1);

    // Vector table: R1, R2, R3, R6
    for (int i = 0; i < NV; i++) begin
      logic [82:0] v;
      longint expSum;
      v = VEC[i];
      expSum = longint'(v[15:0]) + longint'(v[31:16]) + longint'(v[47:32]) + longint'(v[63:48]);
      @(negedge clk);
      altSel    = v[82];
      freeSpace = v[81:64];
      if (v[82]) begin
        altLen = v[63:0];
      end else begin
        lenLoadVal = v[63:0];
        lenLoadVld = 4'hF;
      end
      @(negedge clk);
      lenLoadVld = 4'h0;
      @(negedge clk);
      chk(v[82] ? "R3" : "R1", $sformatf("vec%0d lenSum", i), lenSum, expSum);
      chk(expSum >= 262140 ? "R6" : "R2", $sformatf("vec%0d reqEnable", i),
          reqEnable, (longint'(v[81:64]) > expSum) ? 1 : 0);
    end

    // R3: registers retained under alternate path
    @(negedge clk);
    altSel = 1'b1; altLen = {16'd4, 16'd3, 16'd2, 16'd1}; freeSpace = 18'd11;
    @(negedge clk);
    chk("R3", "alt sum", lenSum, 10);
    chk("R3", "alt enable", reqEnable, 1);
    altSel = 1'b0;
    @(negedge clk);
    chk("R3", "registers retained", lenSum, 262140);
    chk("R3", "enable from registers", reqEnable, 0);

    // R4: completion clears; load wins over completion
    freeSpace = 18'd1000;
    loadAll(16'd40, 16'd30, 16'd20, 16'd10);
    chDone = 4'b0010;
    @(negedge clk);
    chDone = 4'b0000;
    @(negedge clk);
    chk("R4", "done clears ch1", lenSum, 80);
    chDone = 4'b1001; lenLoadVld = 4'b0001; lenLoadVal = {48'd0, 16'd7};
    @(negedge clk);
    chDone = 4'b0000; lenLoadVld = 4'b0000;
    @(negedge clk);
    chk("R4", "load beats done", lenSum, 37);

    // R8: one-edge latency on freeSpace, with exact boundary
    freeSpace = 18'd37;
    @(negedge clk);
    chk("R8", "free equals total", reqEnable, 0);
    freeSpace = 18'd38;
    #2;
    chk("R8", "no change before edge", reqEnable, 0);
    @(negedge clk);
    chk("R8", "free above total", reqEnable, 1);

    // R7: stale large lengths lock the gate; reload recovers
    freeSpace = 18'd1000;
    loadAll(16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF);
    chk("R7", "locked by large lengths", reqEnable, 0);
    loadAll(16'd5, 16'd5, 16'd5, 16'd5);
    chk("R7", "reload sum", lenSum, 20);
    chk("R7", "gate reopened", reqEnable, 1);

    // R5: asynchronous assertion mid-run, synchronous release
    @(negedge clk);
    #3 rstAsyncN = 1'b0;
    #1;
    chk("R5", "async clear enable", reqEnable, 0);
    chk("R5", "async clear sum", lenSum, 0);
    @(negedge clk);
    rstAsyncN = 1'b1;
    lenLoadVld = 4'b0001; lenLoadVal = {48'd0, 16'd9};
    @(negedge clk);
    lenLoadVld = 4'b0000;
    repeat (3) @(negedge clk);
    chk("R5", "load during release ignored", lenSum, 0);
    chk("R5", "enable after release", reqEnable, 1);
    @(negedge clk);
    lenLoadVld = 4'b0001;
    @(negedge clk);
    lenLoadVld = 4'b0000;
    @(negedge clk);
    chk("R1", "load after release", lenSum, 9);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule